// File: doc/BRIEF.md
# Stop-Mode Key Wake-Up Controller

This block decides when a small processor core may stop its clock, and when it may start it again. The core raises a one-cycle stop request. The block then parks in a stop state, with its stop-active flag gating the core clock. It leaves that state on a wake condition taken from one dedicated wake pin and four key inputs. Before the core runs again, a programmable warm-up count gives the oscillator time to settle. The block then issues a single resume pulse. All logic runs on an always-running slow clock, so detection keeps working while the core clock is gated.

Two release modes are offered. In level mode, the block wakes while the wake pin is high or while any enabled key input is low. A stop request made while such a condition is already present bypasses the stop state and goes straight to warm-up. In edge mode, only a fresh low-to-high transition of the wake pin releases the stop state, and the key inputs play no part. A write-only control byte carries the four key enables in its upper nibble.

Every pin passes through a two-flop synchronizer. The state machine has four states:
- RUN: the core runs.
- STOP: the clock is gated.
- WARM: the warm-up count is running.
- RESUME: the one-cycle wake pulse.

It has five named transitions:
- park: RUN to STOP.
- bypass: RUN to WARM.
- wake: STOP to WARM.
- expire: WARM to RESUME.
- rejoin: RESUME to RUN.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, stop_active, warm_busy and resume_pulse are 0, and all four key enables are 0.
- R2: A write with wr_en high stores wr_data bit 4+n as the enable of key n (n = 0..3). Bits 3:0 of the written byte are ignored.
- R3: In level mode (level_mode = 1), the STOP state is left when wake_pin is high or when an enabled key_n input is low. warm_busy rises and stop_active falls three clock edges after the pin changes: two synchronizer stages plus the state register.
- R4: In edge mode (level_mode = 0), the STOP state is left only on a low-to-high transition of wake_pin. A pin that is already high when STOP is entered, or a falling pin, does not release.
- R5: A key input whose enable is 0 never causes release. In edge mode no key input causes release, whatever its enable.
- R6: In level mode, a stop_req made while a release condition is present moves RUN straight to WARM: warm_busy is 1 on the next cycle and stop_active never rises.
- R7: warm_busy stays high for exactly 2^(8+2*warm_sel) cycles, with warm_sel sampled when warm-up starts. stop_active is 0 throughout warm-up.
- R8: resume_pulse is high for exactly one cycle, on the cycle right after the last warm_busy cycle.
- R9: A stop_req is ignored while warm_busy or resume_pulse is high.
- R10: In RUN, a stop_req with no bypass condition sets stop_active on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-running slow clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | control byte write strobe |
| wr_data | input | 8 | control byte; bits 7:4 are the key enables |
| level_mode | input | 1 | 1 = level release, 0 = edge release |
| warm_sel | input | 2 | warm-up length select |
| stop_req | input | 1 | one-cycle stop request from the core |
| wake_pin | input | 1 | dedicated wake pin, active high |
| key_n | input | 4 | key inputs, active low |
| stop_active | output | 1 | clock-gate flag, high in STOP |
| warm_busy | output | 1 | high during warm-up |
| resume_pulse | output | 1 | one-cycle pulse as the core resumes |

## Verification
The main function is driven from a table of stop attempts. Each entry sets the mode, the enable nibble, the wake pin and the key levels, and expects either a park or a bypass. The entries separate enabled from disabled keys, a key from the wake pin, and level mode from edge mode with the same pins. Directed cases then wake a parked block through a key and through a pin edge, and count the cycle of release. They show that a pin already high, or a falling pin, leaves edge mode parked. They also measure the warm-up length for three selects and fire stop requests inside warm-up.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_WARM   = 2'd2,
        ST_RESUME = 2'd3
    } wake_state_e;

endpackage

// File: rtl/stopwake_sync.sv
module stopwake_sync #(
    parameter int              WIDTH     = 1,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RESET_VAL;
            q      <= RESET_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/stopwake_release.sv
module stopwake_release #(
    parameter int KEYS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            level_mode,
    input  logic [KEYS-1:0] key_en,
    input  logic            pin_s,
    input  logic [KEYS-1:0] key_s,
    output logic            level_hit,
    output logic            edge_hit
);

    logic pin_prev;
    logic key_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin_s;
    end

    // One stage per key: a key counts only when enabled and pulled low.
    logic [KEYS-1:0] key_low_en;
    for (genvar k = 0; k < KEYS; k++) begin : g_key
        assign key_low_en[k] = key_en[k] & ~key_s[k];
    end

    always_comb begin
        key_hit   = |key_low_en;
        level_hit = level_mode & (pin_s | key_hit);
        edge_hit  = ~level_mode & pin_s & ~pin_prev;
    end

    // R4: an edge release needs the pin low one cycle and high the next
    a_r4_edge_is_rise: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |-> (pin_s && !$past(pin_s)));

    // R5: with every key disabled and the pin low, no level release
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (key_en == '0 && !pin_s) |-> !level_hit);

endmodule

// File: rtl/stopwake_warmup.sv
module stopwake_warmup #(
    parameter int BASE_LOG = 8,
    parameter int STEP_LOG = 2,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output logic             running,
    output logic             expire
);

    localparam int MAX_LOG = BASE_LOG + STEP_LOG * ((1 << SEL_W) - 1);
    localparam int CNT_W   = MAX_LOG;

    logic [CNT_W-1:0] cnt;

    function automatic logic [CNT_W-1:0] start_value(input logic [SEL_W-1:0] s);
        logic [CNT_W:0] len;
        len = (CNT_W+1)'(1) << (BASE_LOG + STEP_LOG * int'(s));
        return CNT_W'(len - 1'b1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= start_value(sel);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign expire = running && (cnt == '0);

    // R7: a new count never starts over a running one
    a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !running);

    // R7: the count only falls while running
    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && running && !$past(load)) |-> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl #(
    parameter int KEYS     = 4,
    parameter int DATA_W   = 8,
    parameter int BASE_LOG = 8,
    parameter int STEP_LOG = 2,
    parameter int SEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              level_mode,
    input  logic [SEL_W-1:0]  warm_sel,
    input  logic              stop_req,
    input  logic              wake_pin,
    input  logic [KEYS-1:0]   key_n,
    output logic              stop_active,
    output logic              warm_busy,
    output logic              resume_pulse
);
    import stopwake_pkg::*;

    localparam int EN_LSB = DATA_W - KEYS;

    wake_state_e state, state_nx;
    logic [KEYS-1:0] key_en;
    logic            pin_s;
    logic [KEYS-1:0] key_s;
    logic            level_hit, edge_hit;
    logic            warm_load, warm_run, warm_expire;

    // control byte: only the enable nibble is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     key_en <= '0;
        else if (wr_en) key_en <= wr_data[DATA_W-1:EN_LSB];
    end

    stopwake_sync #(.WIDTH(1), .RESET_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(wake_pin), .q(pin_s));

    stopwake_sync #(.WIDTH(KEYS), .RESET_VAL({KEYS{1'b1}})) u_key_sync (
        .clk(clk), .rst_n(rst_n), .d(key_n), .q(key_s));

    stopwake_release #(.KEYS(KEYS)) u_release (
        .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .key_en(key_en),
        .pin_s(pin_s), .key_s(key_s), .level_hit(level_hit), .edge_hit(edge_hit));

    stopwake_warmup #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG), .SEL_W(SEL_W)) u_warm (
        .clk(clk), .rst_n(rst_n), .load(warm_load), .sel(warm_sel),
        .running(warm_run), .expire(warm_expire));

    // next state and warm-up load
    always_comb begin
        state_nx  = state;
        warm_load = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (stop_req) begin
                    if (level_hit) begin      // bypass
                        state_nx  = ST_WARM;
                        warm_load = 1'b1;
                    end else begin            // park
                        state_nx  = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (level_hit || edge_hit) begin  // wake
                    state_nx  = ST_WARM;
                    warm_load = 1'b1;
                end
            end
            ST_WARM: begin
                if (warm_expire) state_nx = ST_RESUME;  // expire
            end
            ST_RESUME: state_nx = ST_RUN;               // rejoin
            default:   state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        stop_active  = (state == ST_STOP);
        warm_busy    = (state == ST_WARM);
        resume_pulse = (state == ST_RESUME);
    end

    // R7: the clock gate and warm-up never overlap
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_active && warm_busy));

    // R8: the resume pulse lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);

    // R8: the resume pulse follows warm-up
    a_r8_after_warm: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> $past(warm_busy));

    // R9: no park straight out of warm-up or resume
    a_r9_warm_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_busy || resume_pulse) |=> !stop_active);

    // R6: a request with a release present bypasses the stop state
    a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req && level_mode && level_hit) |=> (warm_busy && !stop_active));

    // R10: a request with no release present parks
    a_r10_park: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && stop_req && !level_hit) |=> stop_active);

    // R4: in edge mode the stop state ends only with a pin rise
    a_r4_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_active && !level_mode && !edge_hit) |=> stop_active);

endmodule

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       level_mode;
    logic [1:0] warm_sel;
    logic       stop_req;
    logic       wake_pin;
    logic [3:0] key_n;
    logic       stop_active, warm_busy, resume_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_wake_ctrl i_stop_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .level_mode(level_mode), .warm_sel(warm_sel), .stop_req(stop_req),
        .wake_pin(wake_pin), .key_n(key_n), .stop_active(stop_active),
        .warm_busy(warm_busy), .resume_pulse(resume_pulse));

    // vector: [10] level, [9:6] enables, [5] pin, [4:1] key_n, [0] expect bypass
    localparam logic [10:0] VEC [0:7] = '{
        {1'b1, 4'b0000, 1'b0, 4'b0000, 1'b0},
        {1'b1, 4'b0001, 1'b0, 4'b1110, 1'b1},
        {1'b1, 4'b1000, 1'b0, 4'b0111, 1'b1},
        {1'b1, 4'b1000, 1'b0, 4'b1110, 1'b0},
        {1'b1, 4'b0000, 1'b1, 4'b1111, 1'b1},
        {1'b0, 4'b0000, 1'b1, 4'b1111, 1'b0},
        {1'b0, 4'b1111, 1'b0, 4'b0000, 1'b0},
        {1'b1, 4'b0110, 1'b0, 4'b1001, 1'b1}
    };

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_en(input logic [3:0] en);
        wr_en   = 1'b1;
        wr_data = {en, 4'b1010};
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic request_stop();
        stop_req = 1'b1;
        tick();
        stop_req = 1'b0;
    endtask

    // from inside warm-up: wait past it and the resume cycle
    task automatic finish_warm();
        int guard = 0;
        while (warm_busy && guard < 20000) begin
            tick();
            guard++;
        end
        tick(2);
    endtask

    // bring a parked block back to RUN with a pin rise
    task automatic recover();
        if (stop_active) begin
            wake_pin = 1'b0;
            key_n    = 4'b1111;
            tick(4);
            wake_pin = 1'b1;
            tick(3);
        end
        finish_warm();
        wake_pin = 1'b0;
        key_n    = 4'b1111;
        tick(3);
    endtask

    // count warm_busy cycles, then check the pulse
    task automatic measure_warm(input string req, input int exp_len);
        int len = 0;
        while (warm_busy && len < 20000) begin
            if (stop_active) chk("R7 stop_active low in warm-up", 1, 0);
            tick();
            len++;
        end
        chk(req, len, exp_len);
        chk("R8 resume pulse after warm-up", int'(resume_pulse), 1);
        tick();
        chk("R8 resume pulse one cycle", int'(resume_pulse), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        wr_en      = 1'b0;
        wr_data    = '0;
        level_mode = 1'b1;
        warm_sel   = 2'd0;
        stop_req   = 1'b0;
        wake_pin   = 1'b0;
        key_n      = 4'b1111;
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 stop_active", int'(stop_active), 0);
        chk("R1 warm_busy", int'(warm_busy), 0);
        chk("R1 resume_pulse", int'(resume_pulse), 0);
        // R1: enables reset to 0, so a low key does not bypass
        key_n = 4'b0000;
        tick(3);
        request_stop();
        chk("R1 enables zero after reset (parks)", int'(stop_active), 1);
        tick(10);
        chk("R5 disabled keys keep stop", int'(stop_active), 1);
        recover();

        // table walk: R3/R5/R6/R10
        for (int i = 0; i < 8; i++) begin
            level_mode = VEC[i][10];
            write_en(VEC[i][9:6]);
            wake_pin = VEC[i][5];
            key_n    = VEC[i][4:1];
            tick(3);
            request_stop();
            if (VEC[i][0]) begin
                chk($sformatf("R6 vec%0d bypass warm_busy", i), int'(warm_busy), 1);
                chk($sformatf("R6 vec%0d no stop", i), int'(stop_active), 0);
            end else begin
                chk($sformatf("R10 vec%0d park", i), int'(stop_active), 1);
                tick(5);
                chk($sformatf("R5 vec%0d still parked", i), int'(stop_active), 1);
            end
            recover();
        end

        // R2: low nibble ignored, bit 6 enables key 2; level wake by key
        level_mode = 1'b1;
        wr_en = 1'b1; wr_data = 8'b0100_1111; tick(); wr_en = 1'b0;
        tick(3);
        request_stop();
        chk("R2 park with keys high", int'(stop_active), 1);
        key_n = 4'b1110;              // key 0: low nibble bit was set, must be ignored
        tick(5);
        chk("R2 low nibble ignored", int'(stop_active), 1);
        key_n = 4'b1011;              // key 2 enabled by bit 6
        tick(2);
        chk("R3 key wake not before 3 edges", int'(stop_active), 1);
        tick();
        chk("R3 key wake at 3rd edge", int'(warm_busy), 1);
        chk("R3 stop_active cleared", int'(stop_active), 0);
        measure_warm("R7 warm length sel0", 256);
        key_n = 4'b1111;
        tick(3);

        // R3 level wake by pin, R7 sel1
        warm_sel = 2'd1;
        request_stop();
        wake_pin = 1'b1;
        tick(2);
        chk("R3 pin wake not before 3 edges", int'(stop_active), 1);
        tick();
        chk("R3 pin wake at 3rd edge", int'(warm_busy), 1);
        warm_sel = 2'd0;              // sampled at start: change has no effect
        measure_warm("R7 warm length sel1", 1024);
        wake_pin = 1'b0;
        tick(3);

        // R4 edge mode: pin already high does not release; fall does not; rise does
        level_mode = 1'b0;
        write_en(4'b0000);
        wake_pin = 1'b1;
        tick(4);
        request_stop();
        tick(40);
        chk("R4 high pin at entry no release", int'(stop_active), 1);
        wake_pin = 1'b0;
        tick(10);
        chk("R4 falling pin no release", int'(stop_active), 1);
        wake_pin = 1'b1;
        tick(2);
        chk("R4 rise not before 3 edges", int'(stop_active), 1);
        tick();
        chk("R4 rise releases at 3rd edge", int'(warm_busy), 1);
        // R9: requests during warm-up ignored
        request_stop();
        tick(5);
        request_stop();
        chk("R9 request in warm-up ignored", int'(stop_active), 0);
        measure_warm("R7 warm length sel0 edge", 249);
        tick(3);
        chk("R9 no stop after resume", int'(stop_active), 0);
        wake_pin = 1'b0;
        tick(3);

        // R9: request on the resume cycle ignored; R7 sel3
        level_mode = 1'b1;
        warm_sel = 2'd3;
        wake_pin = 1'b1;
        tick(3);
        request_stop();
        chk("R6 bypass sel3", int'(warm_busy), 1);
        wake_pin = 1'b0;
        begin
            int len = 1;
            while (warm_busy && len < 20000) begin
                tick();
                len++;
            end
            chk("R7 warm length sel3", len - 1, 16384);
        end
        chk("R8 pulse sel3", int'(resume_pulse), 1);
        request_stop();
        chk("R9 request on resume ignored", int'(stop_active), 0);
        chk("R9 no warm after resume req", int'(warm_busy), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule